// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the digital counting side of a pulse-swallow frequency divider. It runs on the fast input clock. A dual-modulus prescaler, modelled as a down-counter, divides that clock by M or M+1. M is 64 or 128, picked by a select input. Each prescaler period clocks two counters: a 7-bit swallow counter and an 11-bit main counter. While the swallow counter has cycles left, the modulus-control line asks for M+1. After that the prescaler divides by M until the main counter runs out. The block emits one single-cycle pulse per output period, so the overall ratio is M·N + A input cycles.

The settings M select, N and A are taken in only at a period boundary. A setting that cannot be counted (A not below N, or N below 5) raises an error flag. Such a setting is ignored, and the last accepted setting stays in force. After reset the accepted setting is M=64, N=5, A=0, until the first boundary samples the inputs. The first boundary is the first clock edge after reset is released.

Top module: `pswallow_div`

## Requirements
- R1: Between two consecutive rising pulses of `pulse_o` there are exactly M·N + A input cycles, and `pulse_o` is high for one input cycle each time.
- R2: `msel_i` = 1 selects M = 64 (moduli 64/65); `msel_i` = 0 selects M = 128 (moduli 128/129).
- R3: `mod_ctl_o` = 1 means the prescaler divides by M+1 and 0 means by M. Within one output period `mod_ctl_o` is high for the first A prescaler periods, which is exactly A·(M+1) input cycles, and low for the rest. It is low in the last input cycle of every period.
- R4: With A = 0, `mod_ctl_o` stays low for the whole period and the period is exactly M·N cycles.
- R5: A change of `msel_i`, `n_i` or `a_i` during a period leaves the length of that period unchanged. The new values govern only the periods that start after the next boundary.
- R6: Inputs with `a_i` ≥ `n_i` or `n_i` < 5 set `cfg_err_o` to 1 one cycle after they are applied. Valid inputs set it to 0. Invalid inputs are never loaded, and the last accepted setting keeps being used.
- R7: While `rst_ni` is low, `pulse_o`, `mod_ctl_o` and `cfg_err_o` are 0.
- R8: The extreme swallow setting A = N−1 works, for example A = 127 with N = 128 and M = 64 (8319 cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msel_i | input | 1 | Modulus select: 1 gives 64/65, 0 gives 128/129 |
| n_i | input | 11 | Main counter preset N (5 to 2047) |
| a_i | input | 7 | Swallow counter preset A (0 to 127, below N) |
| mod_ctl_o | output | 1 | Modulus control: 1 divides by M+1, 0 by M |
| pulse_o | output | 1 | One-cycle pulse per output period |
| cfg_err_o | output | 1 | Applied setting is invalid and is being ignored |

## Verification
The scoreboard measures every period and the number of cycles with `mod_ctl_o` high in it. An off-by-one in the swallow handling would show as a period one or M+1 cycles off. The same error would show as a modulus-control count differing from A·(M+1). A = 0 is checked separately: a design that asserts the control line for one prescaler period before looking at the swallow count would add M+1 cycles. A = N−1 with the wide swallow count checks that the last prescaler period always falls back to M. Invalid settings (A equal to N, N below 5) must raise the flag while the previous period length repeats. Settings that change in mid-period must not shorten or stretch the running period.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int unsigned PRE_LO_DEF = 64;
  localparam int unsigned SW_W_DEF   = 7;
  localparam int unsigned MAIN_W_DEF = 11;
  localparam int unsigned N_MIN_DEF  = 5;
endpackage

// File: rtl/psd_cfg_hold.sv
module psd_cfg_hold #(
  parameter int unsigned SW_W   = pswallow_pkg::SW_W_DEF,
  parameter int unsigned MAIN_W = pswallow_pkg::MAIN_W_DEF,
  parameter int unsigned N_MIN  = pswallow_pkg::N_MIN_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              msel_i,
  input  logic [MAIN_W-1:0] n_i,
  input  logic [SW_W-1:0]   a_i,
  output logic              act_msel_o,
  output logic [MAIN_W-1:0] act_n_o,
  output logic [SW_W-1:0]   act_a_o,
  output logic              nxt_msel_o,
  output logic [MAIN_W-1:0] nxt_n_o,
  output logic [SW_W-1:0]   nxt_a_o,
  output logic              err_o
);
  localparam int unsigned PAD_W = MAIN_W - SW_W;

  logic valid;
  assign valid = ({{PAD_W{1'b0}}, a_i} < n_i) && (n_i >= MAIN_W'(N_MIN));

  // rejected inputs fall back to the accepted setting
  assign nxt_msel_o = valid ? msel_i : act_msel_o;
  assign nxt_n_o    = valid ? n_i    : act_n_o;
  assign nxt_a_o    = valid ? a_i    : act_a_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_msel_o <= 1'b1;
      act_n_o    <= MAIN_W'(N_MIN);
      act_a_o    <= '0;
      err_o      <= 1'b0;
    end else begin
      err_o <= !valid;
      if (load_i) begin
        act_msel_o <= nxt_msel_o;
        act_n_o    <= nxt_n_o;
        act_a_o    <= nxt_a_o;
      end
    end
  end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned PRE_LO = pswallow_pkg::PRE_LO_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic msel_i,
  input  logic big_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = $clog2(2 * PRE_LO + 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  assign tick_o = (pre_q == '0);

  always_comb begin
    if (tick_o) begin
      pre_d = msel_i ? PRE_W'(PRE_LO - 1) : PRE_W'(2 * PRE_LO - 1);
      if (big_i) pre_d = pre_d + PRE_W'(1);
    end else begin
      pre_d = pre_q - PRE_W'(1);
    end
  end

  // reset to zero so the first edge is a boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/psd_swallow_ctl.sv
module psd_swallow_ctl #(
  parameter int unsigned SW_W   = pswallow_pkg::SW_W_DEF,
  parameter int unsigned MAIN_W = pswallow_pkg::MAIN_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [MAIN_W-1:0] nxt_n_i,
  input  logic [SW_W-1:0]   nxt_a_i,
  output logic              ld_o,
  output logic              big_o,
  output logic              mod_o,
  output logic              pulse_o
);
  logic              start_q;
  logic [SW_W-1:0]   sw_q;
  logic [MAIN_W-1:0] main_q;
  logic              period_end;

  assign period_end = tick_i && !start_q && (main_q == MAIN_W'(1));
  assign ld_o       = start_q || period_end;
  // modulus of the prescaler period that begins after this tick
  assign big_o      = ld_o ? (nxt_a_i != '0) : (sw_q > SW_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      sw_q    <= '0;
      main_q  <= '0;
      mod_o   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      start_q <= 1'b0;
      pulse_o <= period_end;
      if (ld_o) begin
        sw_q   <= nxt_a_i;
        main_q <= nxt_n_i;
        mod_o  <= big_o;
      end else if (tick_i) begin
        main_q <= main_q - MAIN_W'(1);
        if (sw_q != '0) sw_q <= sw_q - SW_W'(1);
        mod_o  <= big_o;
      end
    end
  end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int unsigned PRE_LO = pswallow_pkg::PRE_LO_DEF,
  parameter int unsigned SW_W   = pswallow_pkg::SW_W_DEF,
  parameter int unsigned MAIN_W = pswallow_pkg::MAIN_W_DEF,
  parameter int unsigned N_MIN  = pswallow_pkg::N_MIN_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msel_i,
  input  logic [MAIN_W-1:0] n_i,
  input  logic [SW_W-1:0]   a_i,
  output logic              mod_ctl_o,
  output logic              pulse_o,
  output logic              cfg_err_o
);
  logic              ld;
  logic              tick;
  logic              big;
  logic              act_msel, nxt_msel;
  logic [MAIN_W-1:0] act_n, nxt_n;
  logic [SW_W-1:0]   act_a, nxt_a;
  logic              msel_use;

  assign msel_use = ld ? nxt_msel : act_msel;

  psd_cfg_hold #(.SW_W(SW_W), .MAIN_W(MAIN_W), .N_MIN(N_MIN)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .msel_i     (msel_i),
    .n_i        (n_i),
    .a_i        (a_i),
    .act_msel_o (act_msel),
    .act_n_o    (act_n),
    .act_a_o    (act_a),
    .nxt_msel_o (nxt_msel),
    .nxt_n_o    (nxt_n),
    .nxt_a_o    (nxt_a),
    .err_o      (cfg_err_o)
  );

  psd_prescaler #(.PRE_LO(PRE_LO)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .msel_i (msel_use),
    .big_i  (big),
    .tick_o (tick)
  );

  psd_swallow_ctl #(.SW_W(SW_W), .MAIN_W(MAIN_W)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .nxt_n_i (nxt_n),
    .nxt_a_i (nxt_a),
    .ld_o    (ld),
    .big_o   (big),
    .mod_o   (mod_ctl_o),
    .pulse_o (pulse_o)
  );
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
  parameter int unsigned SW_W   = pswallow_pkg::SW_W_DEF,
  parameter int unsigned MAIN_W = pswallow_pkg::MAIN_W_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pulse_i,
  input logic              mod_i,
  input logic              tick_i,
  input logic              ld_i,
  input logic              act_msel_i,
  input logic [MAIN_W-1:0] act_n_i,
  input logic [SW_W-1:0]   act_a_i
);
  localparam int unsigned PAD_W = MAIN_W - SW_W;

  a_r1_pulse_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> !pulse_i);

  a_r3_mod_low_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> !mod_i);

  a_r3_mod_falls_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mod_i) |-> $past(tick_i));

  a_r3_mod_rises_at_ld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_i) |-> $past(ld_i));

  a_r5_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ld_i) |-> ($stable(act_msel_i) && $stable(act_n_i) && $stable(act_a_i)));

  a_r6_act_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {{PAD_W{1'b0}}, act_a_i} < act_n_i);
endmodule

bind pswallow_div pswallow_div_chk #(.SW_W(SW_W), .MAIN_W(MAIN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pulse_i    (pulse_o),
  .mod_i      (mod_ctl_o),
  .tick_i     (tick),
  .ld_i       (ld),
  .act_msel_i (act_msel),
  .act_n_i    (act_n),
  .act_a_i    (act_a)
);

// File: tb/pswallow_div_bench.sv
`timescale 1ns/1ps
module pswallow_div_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msel;
  logic [10:0] n;
  logic [6:0]  a;
  logic        mod_ctl, pulse, cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int    exp_len_q[$];
  int    exp_mod_q[$];
  string exp_tag_q[$];

  int cur_m, cur_n, cur_a;

  always #2 clk = ~clk;

  pswallow_div u_pswallow_div (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .msel_i    (msel),
    .n_i       (n),
    .a_i       (a),
    .mod_ctl_o (mod_ctl),
    .pulse_o   (pulse),
    .cfg_err_o (cfg_err)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // driver: wait for a boundary, apply a new setting, push the in-flight period
  task automatic apply(input bit ms, input int nn, input int aa, input string tag);
    bit ok;
    do @(negedge clk); while (!pulse);
    msel = ms; n = 11'(nn); a = 7'(aa);
    exp_len_q.push_back(cur_m * cur_n + cur_a);
    exp_mod_q.push_back(cur_a * (cur_m + 1));
    exp_tag_q.push_back(tag);
    ok = (aa < nn) && (nn >= 5);
    @(negedge clk);
    check("R6 cfg_err_o", int'(cfg_err), ok ? 0 : 1);
    if (ok) begin
      cur_m = ms ? 64 : 128; cur_n = nn; cur_a = aa;
    end
  endtask

  // monitor: measure each period and its modulus-control cycles
  int  cyc = 0;
  int  modcnt = 0;
  bit  seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse) begin
        if (seen) begin
          if (exp_len_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R1 unexpected pulse got %0d expected %0d", cyc, 0);
          end else begin
            automatic int    el = exp_len_q.pop_front();
            automatic int    em = exp_mod_q.pop_front();
            automatic string et = exp_tag_q.pop_front();
            check({"R1 period ", et}, cyc, el);
            check({"R3 mod_ctl cycles ", et}, modcnt, em);
          end
        end
        seen = 1'b1;
        cyc = 0;
        modcnt = 0;
      end
      cyc++;
      if (mod_ctl) modcnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    msel = 1'b1; n = 11'd5; a = 7'd0;
    cur_m = 64; cur_n = 5; cur_a = 0;
    repeat (3) @(negedge clk);
    check("R7 pulse_o in reset", int'(pulse), 0);
    check("R7 mod_ctl_o in reset", int'(mod_ctl), 0);
    check("R7 cfg_err_o in reset", int'(cfg_err), 0);
    rst_n = 1'b1;

    apply(1'b1, 10, 3,   "R4 A=0 M=64");
    apply(1'b0, 10, 3,   "R3 A=3 M=64");
    apply(1'b0, 5, 4,    "R2 M=128");
    apply(1'b1, 6, 6,    "R8 A=N-1 M=128");
    apply(1'b1, 4, 0,    "R6 A=N rejected");
    apply(1'b1, 128, 127, "R6 N<5 rejected");
    apply(1'b0, 20, 0,   "R8 A=127 N=128");
    apply(1'b1, 7, 2,    "R5 R4 A=0 M=128");
    apply(1'b1, 7, 2,    "R5 M=64 N=7 A=2");
    do @(negedge clk); while (!pulse);
    @(negedge clk);
    check("R5 scoreboard drained", exp_len_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule